// File: doc/BRIEF.md
# Exception and Interrupt Control Registers

This block holds the four system-control registers that a 32-bit RISC core uses to enter and leave exception handlers: a machine status word, an exception cause word, the saved exception program counter and the faulting virtual address. Software reaches them through a five-bit register number with a write strobe and a combinational read port. Hardware changes them when the core takes a trap or an interrupt, and again when the handler returns.

The core presents a synchronous exception request with its five-bit code, the PC of the instruction at fault and the address involved. It also presents five level-sensitive hardware interrupt lines and a return strobe. In the same cycle the block answers with a take signal and the fixed handler address. The status word keeps a three-level stack of privilege/enable pairs. Entry pushes this stack and return pops it, so a handler always starts in kernel mode with interrupts off.

Top module: `sysc_exc_regs`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 all read 0, `user_mode_o` and `irq_en_o` are 0, and `take_exc_o` is 0.
- R2: The register numbers are 8 (faulting address), 12 (status), 13 (cause) and 14 (EPC). Any other number reads 0. Only status bits 15:8 and 5:0 can be written and read back; every other status bit reads 0.
- R3: Status bits 5:0 form three pairs: current in 1:0, previous in 3:2 and old in 5:4. Within each pair, bit 0 is interrupt enable (1 = enabled) and bit 1 is privilege (0 = kernel, 1 = user). `irq_en_o` shows status bit 0 and `user_mode_o` shows status bit 1.
- R4: On a taken exception or interrupt, status bits 5:0 become the old bits 3:0 shifted up by two with bits 1:0 cleared. The mask bits 15:8 stay unchanged.
- R5: A return strobe sets status bits 3:0 to the old bits 5:2 and leaves bits 5:4 as they were. If entry and return arrive in the same cycle, entry wins.
- R6: Cause bits 6:2 load the exception code on every entry. An interrupt loads code 0. Bits 10:8 are software pending levels that software writes. No other cause bit can be written by software.
- R7: Cause bit 11+n copies hardware line n one cycle later. This happens whatever the enable and mask bits hold.
- R8: An interrupt is taken in the same cycle (`take_exc_o` high) only when status bit 0 is 1 and cause bits 15:8 AND status bits 15:8 is nonzero.
- R9: A synchronous exception request always raises `take_exc_o`. When an interrupt is also due in that cycle, the request's code is the one recorded.
- R10: EPC loads `exc_pc_i` on every entry and can also be written by software. `vector_o` is always 0x8000_0180.
- R11: The faulting-address register loads `exc_badaddr_i` only for exception codes 4 and 5. Software writes to it have no effect.
- R12: A software write to status in a cycle with an entry or a return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register number for read and write |
| reg_we_i | input | 1 | Software write strobe |
| reg_wdata_i | input | 32 | Software write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 5 | Code of the requested exception |
| exc_pc_i | input | 32 | PC of the instruction at fault or being interrupted |
| exc_badaddr_i | input | 32 | Address involved in the fault |
| hw_irq_i | input | 5 | Hardware interrupt lines |
| eret_i | input | 1 | Return-from-exception strobe |
| take_exc_o | output | 1 | Exception or interrupt taken this cycle |
| vector_o | output | 32 | Handler entry address |
| user_mode_o | output | 1 | Current privilege bit (1 = user) |
| irq_en_o | output | 1 | Current interrupt enable |

## Verification
The bench walks all 64 values of the privilege/enable stack through an entry and a return. A design that shifted the wrong way, or that cleared the old pair on return, produces a wrong status word at once. Every one of the 32 codes is raised to confirm the faulting address moves only for codes 4 and 5; a design that loaded it too often would corrupt it on a syscall. Each pending-line pattern is crossed with single-bit, empty and full masks, and with the enable bit both off and on, to expose a slipped line-to-mask bit alignment. Collision cases are also driven: an interrupt against a synchronous request, entry against return, and a software write against either. A design with the wrong priority records code 0, pops instead of pushing, or lets the write overwrite the pushed stack.

// File: rtl/sysc_pkg.sv
package sysc_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned RNUM_W   = 5;
  localparam int unsigned NUM_HW   = 5;
  localparam int unsigned NUM_SW   = 3;
  localparam int unsigned NUM_LVL  = NUM_HW + NUM_SW;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned STK_W    = 6;
  localparam int unsigned MASK_LSB = 8;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned HWP_LSB  = MASK_LSB + NUM_SW;

  localparam logic [RNUM_W-1:0] RN_BADVA  = 5'd8;
  localparam logic [RNUM_W-1:0] RN_STATUS = 5'd12;
  localparam logic [RNUM_W-1:0] RN_CAUSE  = 5'd13;
  localparam logic [RNUM_W-1:0] RN_EPC    = 5'd14;

  localparam logic [CODE_W-1:0] EC_INT    = 5'd0;
  localparam logic [CODE_W-1:0] EC_ADR_LD = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADR_ST = 5'd5;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/sysc_status.sv
module sysc_status
  import sysc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  stk_op_e            op_i,
  input  logic               sw_we_i,
  input  logic [NUM_LVL-1:0] sw_mask_i,
  input  logic [STK_W-1:0]   sw_stk_i,
  output logic [NUM_LVL-1:0] mask_o,
  output logic [STK_W-1:0]   stk_o
);
  logic [NUM_LVL-1:0] mask_q;
  logic [STK_W-1:0]   stk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stk_q  <= '0;
    end else begin
      case (op_i)
        STK_PUSH: stk_q <= {stk_q[STK_W-3:0], 2'b00};
        STK_POP:  stk_q <= {stk_q[STK_W-1:STK_W-2], stk_q[STK_W-1:2]};
        default: begin
          if (sw_we_i) begin
            mask_q <= sw_mask_i;
            stk_q  <= sw_stk_i;
          end
        end
      endcase
    end
  end

  assign mask_o = mask_q;
  assign stk_o  = stk_q;
endmodule

// File: rtl/sysc_cause.sv
module sysc_cause
  import sysc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_HW-1:0]  hw_irq_i,
  input  logic [NUM_LVL-1:0] mask_i,
  input  logic               latch_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               sw_we_i,
  input  logic [NUM_SW-1:0]  sw_pend_i,
  output logic [XLEN-1:0]    cause_o,
  output logic               irq_hit_o
);
  logic [NUM_HW-1:0] hwp_q;
  logic [NUM_SW-1:0] swp_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hwp_q  <= '0;
      swp_q  <= '0;
      code_q <= '0;
    end else begin
      hwp_q <= hw_irq_i;
      if (sw_we_i) swp_q <= sw_pend_i;
      if (latch_i) code_q <= code_i;
    end
  end

  assign irq_hit_o = |({hwp_q, swp_q} & mask_i);

  always_comb begin
    cause_o = '0;
    cause_o[HWP_LSB +: NUM_HW]   = hwp_q;
    cause_o[MASK_LSB +: NUM_SW]  = swp_q;
    cause_o[CODE_LSB +: CODE_W]  = code_q;
  end
endmodule

// File: rtl/sysc_arb.sv
module sysc_arb
  import sysc_pkg::*;
(
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              ie_i,
  input  logic              irq_hit_i,
  input  logic              eret_i,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o,
  output stk_op_e           op_o,
  output logic              badva_we_o
)
;
  logic irq_take;

  assign irq_take   = ie_i & irq_hit_i;
  assign take_o     = exc_req_i | irq_take;
  // synchronous requests outrank interrupts
  assign code_o     = exc_req_i ? exc_code_i : EC_INT;
  assign badva_we_o = exc_req_i & ((exc_code_i == EC_ADR_LD) | (exc_code_i == EC_ADR_ST));

  always_comb begin
    if (take_o)      op_o = STK_PUSH;
    else if (eret_i) op_o = STK_POP;
    else             op_o = STK_HOLD;
  end
endmodule

// File: rtl/sysc_exc_regs.sv
module sysc_exc_regs
  import sysc_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR_ADDR = 32'h8000_0180
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RNUM_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [XLEN-1:0]   reg_wdata_i,
  output logic [XLEN-1:0]   reg_rdata_o,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   exc_pc_i,
  input  logic [XLEN-1:0]   exc_badaddr_i,
  input  logic [NUM_HW-1:0] hw_irq_i,
  input  logic              eret_i,
  output logic              take_exc_o,
  output logic [XLEN-1:0]   vector_o,
  output logic              user_mode_o,
  output logic              irq_en_o
);
  logic [NUM_LVL-1:0] mask_w;
  logic [STK_W-1:0]   stk_w;
  logic [XLEN-1:0]    status_w;
  logic [XLEN-1:0]    cause_w;
  logic [XLEN-1:0]    epc_q;
  logic [XLEN-1:0]    badva_q;
  logic               irq_hit_w;
  logic               take_w;
  logic               badva_we_w;
  logic [CODE_W-1:0]  code_w;
  stk_op_e            op_w;
  logic               we_status, we_cause, we_epc;

  assign we_status = reg_we_i & (reg_addr_i == RN_STATUS);
  assign we_cause  = reg_we_i & (reg_addr_i == RN_CAUSE);
  assign we_epc    = reg_we_i & (reg_addr_i == RN_EPC);

  sysc_arb u_arb (
    .exc_req_i  (exc_req_i),
    .exc_code_i (exc_code_i),
    .ie_i       (stk_w[0]),
    .irq_hit_i  (irq_hit_w),
    .eret_i     (eret_i),
    .take_o     (take_w),
    .code_o     (code_w),
    .op_o       (op_w),
    .badva_we_o (badva_we_w)
  );

  sysc_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_w),
    .sw_we_i   (we_status),
    .sw_mask_i (reg_wdata_i[MASK_LSB +: NUM_LVL]),
    .sw_stk_i  (reg_wdata_i[STK_W-1:0]),
    .mask_o    (mask_w),
    .stk_o     (stk_w)
  );

  sysc_cause u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_irq_i  (hw_irq_i),
    .mask_i    (mask_w),
    .latch_i   (take_w),
    .code_i    (code_w),
    .sw_we_i   (we_cause),
    .sw_pend_i (reg_wdata_i[MASK_LSB +: NUM_SW]),
    .cause_o   (cause_w),
    .irq_hit_o (irq_hit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      badva_q <= '0;
    end else begin
      if (take_w)      epc_q <= exc_pc_i;
      else if (we_epc) epc_q <= reg_wdata_i;
      if (badva_we_w)  badva_q <= exc_badaddr_i;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[MASK_LSB +: NUM_LVL] = mask_w;
    status_w[STK_W-1:0]           = stk_w;
  end

  always_comb begin
    case (reg_addr_i)
      RN_BADVA:  reg_rdata_o = badva_q;
      RN_STATUS: reg_rdata_o = status_w;
      RN_CAUSE:  reg_rdata_o = cause_w;
      RN_EPC:    reg_rdata_o = epc_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign take_exc_o  = take_w;
  assign vector_o    = VECTOR_ADDR;
  assign user_mode_o = stk_w[1];
  assign irq_en_o    = stk_w[0];
endmodule

// File: rtl/sysc_exc_regs_chk.sv
module sysc_exc_regs_chk
  import sysc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exc_req_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic [XLEN-1:0]   exc_pc_i,
  input logic              eret_i,
  input logic              take_exc_o,
  input logic              user_mode_o,
  input logic              irq_en_o,
  input logic [XLEN-1:0]   status_w,
  input logic [XLEN-1:0]   cause_w,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   badva_q
);
  a_r4_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |=> (status_w[5:0] == {$past(status_w[3:0]), 2'b00}) && !user_mode_o && !irq_en_o);

  a_r5_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !take_exc_o) |=> status_w[5:0] == {$past(status_w[5:4]), $past(status_w[5:2])});

  a_r4_mask_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |=> $stable(status_w[15:8]));

  a_r9_sync_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> cause_w[6:2] == $past(exc_code_i));

  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_o && !exc_req_i) |-> !take_exc_o);

  a_r10_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |=> epc_q == $past(exc_pc_i));

  a_r11_badva_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_req_i && (exc_code_i == EC_ADR_LD || exc_code_i == EC_ADR_ST)) |=> $stable(badva_q));
endmodule

bind sysc_exc_regs sysc_exc_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_req_i   (exc_req_i),
  .exc_code_i  (exc_code_i),
  .exc_pc_i    (exc_pc_i),
  .eret_i      (eret_i),
  .take_exc_o  (take_exc_o),
  .user_mode_o (user_mode_o),
  .irq_en_o    (irq_en_o),
  .status_w    (status_w),
  .cause_w     (cause_w),
  .epc_q       (epc_q),
  .badva_q     (badva_q)
);

// File: tb/sysc_exc_regs_test.sv
module sysc_exc_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        exc_req_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic [31:0] exc_pc_i = '0;
  logic [31:0] exc_badaddr_i = '0;
  logic [4:0]  hw_irq_i = '0;
  logic        eret_i = 1'b0;
  logic        take_exc_o;
  logic [31:0] vector_o;
  logic        user_mode_o;
  logic        irq_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysc_exc_regs uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .exc_req_i(exc_req_i), .exc_code_i(exc_code_i), .exc_pc_i(exc_pc_i), .exc_badaddr_i(exc_badaddr_i),
    .hw_irq_i(hw_irq_i), .eret_i(eret_i),
    .take_exc_o(take_exc_o), .vector_o(vector_o), .user_mode_o(user_mode_o), .irq_en_o(irq_en_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr_i  = a;
    reg_wdata_i = d;
    reg_we_i    = 1'b1;
    tick();
    reg_we_i    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, e, mbad;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    tick();

    // R1 reset state
    for (int a = 8; a <= 14; a++) begin
      rd(5'(a), d);
      chk("R1 reset regs", d, 32'h0);
    end
    chk("R1 flags", {29'b0, take_exc_o, user_mode_o, irq_en_o}, 32'h0);

    // R2 register map, writable fields; R11 faulting address read-only; R10 EPC write
    wr(5'd12, 32'hFFFF_FFFF);
    wr(5'd14, 32'h1234_5678);
    wr(5'd8,  32'hDEAD_BEEF);
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d);
      e = (a == 12) ? 32'h0000_FF3F : (a == 14) ? 32'h1234_5678 : 32'h0;
      chk((a == 8) ? "R11 badva read-only" : "R2 register map", d, e);
    end
    chk("R10 vector", vector_o, 32'h8000_0180);
    wr(5'd12, 32'h0);
    // R6 only software pending bits writable in cause
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, d);
    chk("R6 cause sw write", d, 32'h0000_0700);
    wr(5'd13, 32'h0);

    // R3 R4 R5 stack sweep
    for (int v = 0; v < 64; v++) begin
      logic [5:0] p;
      wr(5'd12, 32'(v));
      chk("R3 irq_en", {31'b0, irq_en_o}, 32'(v & 1));
      chk("R3 user_mode", {31'b0, user_mode_o}, 32'((v >> 1) & 1));
      exc_req_i = 1'b1; exc_code_i = 5'd8; exc_pc_i = 32'h1000 + 32'(v * 4);
      #1;
      chk("R9 take on request", {31'b0, take_exc_o}, 32'h1);
      tick();
      exc_req_i = 1'b0;
      p = 6'((v << 2) & 32'h3C);
      rd(5'd12, d);
      chk("R4 entry push", d, {26'b0, p});
      chk("R4 kernel disabled", {30'b0, user_mode_o, irq_en_o}, 32'h0);
      rd(5'd14, d);
      chk("R10 epc", d, 32'h1000 + 32'(v * 4));
      eret_i = 1'b1;
      tick();
      eret_i = 1'b0;
      rd(5'd12, d);
      chk("R5 return pop", d, {26'b0, (p & 6'h30) | (p >> 2)});
    end

    // R6 and R11 code sweep
    wr(5'd12, 32'h0);
    mbad = 32'h0;
    for (int c = 0; c < 32; c++) begin
      exc_req_i = 1'b1; exc_code_i = 5'(c);
      exc_pc_i = 32'h2000 + 32'(c); exc_badaddr_i = 32'hA000_0000 + 32'(c);
      tick();
      exc_req_i = 1'b0;
      if (c == 4 || c == 5) mbad = 32'hA000_0000 + 32'(c);
      rd(5'd13, d);
      chk("R6 cause code", d, 32'(c) << 2);
      rd(5'd8, d);
      chk("R11 badva", d, mbad);
      eret_i = 1'b1;
      tick();
      eret_i = 1'b0;
    end

    // R7 pending while disabled
    wr(5'd12, 32'h0000_FF00);
    for (int p = 0; p < 32; p++) begin
      hw_irq_i = 5'(p);
      tick();
      chk("R8 no take when disabled", {31'b0, take_exc_o}, 32'h0);
      rd(5'd13, d);
      chk("R7 pending follows lines", d & 32'h0000_F800, 32'(p) << 11);
    end
    hw_irq_i = '0;
    tick();

    // R8 mask x pending sweep
    for (int mi = 0; mi < 10; mi++) begin
      logic [7:0] m;
      m = (mi < 8) ? 8'(1 << mi) : ((mi == 8) ? 8'h00 : 8'hFF);
      for (int p = 0; p < 32; p++) begin
        logic hit;
        hit = |({5'(p), 3'b000} & m);
        wr(5'd12, {16'b0, m, 8'h01});
        hw_irq_i = 5'(p);
        tick();
        chk("R8 take decision", {31'b0, take_exc_o}, {31'b0, hit});
        hw_irq_i = '0;
        exc_pc_i = 32'h4000 + 32'(p);
        tick();
        rd(5'd12, d);
        chk("R8 status after", d, {16'b0, m, hit ? 8'h04 : 8'h01});
        if (hit) begin
          rd(5'd13, d);
          chk("R6 interrupt code", d & 32'h7C, 32'h0);
        end
      end
    end

    // R8 software pending level
    wr(5'd12, 32'h0);
    wr(5'd13, 32'h0000_0400);
    wr(5'd12, 32'h0000_0401);
    chk("R8 software level take", {31'b0, take_exc_o}, 32'h1);
    wr(5'd13, 32'h0);
    rd(5'd12, d);
    chk("R8 software level entry", d, 32'h0000_0404);

    // R9 priority of request over interrupt
    wr(5'd12, 32'h0000_FF01);
    hw_irq_i = 5'b00001;
    tick();
    chk("R9 interrupt due", {31'b0, take_exc_o}, 32'h1);
    exc_req_i = 1'b1; exc_code_i = 5'd12; exc_pc_i = 32'h3000; hw_irq_i = '0;
    tick();
    exc_req_i = 1'b0;
    rd(5'd13, d);
    chk("R9 request code wins", d & 32'h7C, 32'd12 << 2);
    rd(5'd14, d);
    chk("R9 epc", d, 32'h3000);

    // R12 write discarded against entry and return
    wr(5'd12, 32'h0000_0005);
    reg_addr_i = 5'd12; reg_wdata_i = 32'h0000_FFFF; reg_we_i = 1'b1;
    exc_req_i = 1'b1; exc_code_i = 5'd8;
    tick();
    reg_we_i = 1'b0; exc_req_i = 1'b0;
    rd(5'd12, d);
    chk("R12 write vs entry", d, 32'h0000_0014);
    reg_addr_i = 5'd12; reg_wdata_i = 32'h0000_FF3F; reg_we_i = 1'b1; eret_i = 1'b1;
    tick();
    reg_we_i = 1'b0; eret_i = 1'b0;
    rd(5'd12, d);
    chk("R12 write vs return", d, 32'h0000_0015);
    exc_req_i = 1'b1; eret_i = 1'b1;
    tick();
    exc_req_i = 1'b0; eret_i = 1'b0;
    rd(5'd12, d);
    chk("R5 entry beats return", d, 32'h0000_0014);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule